// File: doc/BRIEF.md
# Video DRAM Operation-Cycle Decoder and Mask/Color Registers

This block is the control front end of a dual-port video DRAM. It runs on a system clock and watches the active-low row and column strobes. On a falling row strobe it latches the strobe-time pin pattern and the data pins. Some cycles are fully known at that point. For the others, it waits for the falling column strobe and resolves the cycle from the special-function flag sampled there.

The block keeps the write-mask register, the flag that makes the mask persistent, the color register, the boundary (stop) flag and a refresh row counter. Downstream datapath logic receives the decoded cycle code, the per-bit write enables and the write data. The write data is either the latched pin value or the stored color.

Every output is a plain status signal qualified by `cyc_valid`. There is no stream interface and no back-pressure: the strobes pace the block, and the datapath has to take the report while `cyc_valid` is high.

Top module: `vram_cycle_ctrl`

## Requirements
- R1: After reset, `cyc_valid`, `cyc_illegal`, `mask_active`, `write_mask`, `color`, `persist`, `boundary_on` and `refresh_row` are all zero.
- R2: A row fall is a clock edge where `row_stb_n` is 0 and was 1 on the previous edge. The decode uses a write-enable level WE, which is `wr_hi_n & wr_lo_n`. With `col_stb_n` low at the row fall, the pair WE/`func_flag` decodes as follows:
  - 01 gives code 1 (refresh, set stop).
  - 10 gives code 2 (refresh, reset registers).
  - 11 gives code 3 (plain refresh).
  - 00 gives code 4 (option cycle) when `xfer_oe_n` is 0, and code 31 (illegal) when `xfer_oe_n` is 1.

  `cyc_valid` rises on the clock after the row fall.
- R3: With `col_stb_n` high and `xfer_oe_n` low at the row fall, WE/`func_flag` gives code 5 for 00 (masked write transfer), 6 for 01 (masked split write transfer), 7 for 10 (read transfer) and 8 for 11 (split read transfer). The code is valid the clock after the row fall.
- R4: With `col_stb_n` and `xfer_oe_n` both high at the row fall, WE/`func_flag` = 01 gives code 13 (masked flash write), valid the clock after the row fall. The other pairs stay invalid until the first column fall, and `func_flag` sampled at that fall picks the code (value for flag 0 / value for flag 1):
  - 00: 9 (masked read/write) / 10 (masked block write).
  - 10: 11 (read/write) / 12 (block write).
  - 11: 14 (load mask) / 15 (load color).
- R5: `func_flag_rsv` high at the row fall gives code 31, with `cyc_illegal` high, whatever the other pins are.
- R6: Once valid, the code stays fixed through later column edges. `cyc_valid` is 0 on the clock after any edge where `row_stb_n` is high.
- R7: A row fall with `col_stb_n` high, `func_flag_rsv` low and WE low while `persist` is 0 loads `write_mask` from `pin_data` and sets `persist`.
- R8: While `persist` is 1, masked cycles leave `write_mask` unchanged.
- R9: Code 14 loads `write_mask` from `pin_data` at the column fall and sets `persist`, whatever its previous value.
- R10: Code 2 clears `write_mask`, `persist` and `boundary_on`. Code 1 sets `boundary_on`.
- R11: `refresh_row` (9 bits) adds one for each cycle with code 1, 2 or 3, wraps after 511 to 0, and changes at no other time.
- R12: Code 15 loads `color` from `pin_data` at the column fall. For codes 10, 12 and 13, `wr_data` is `color`. For all other valid cycles it is the `pin_data` latched at the edge that completed the cycle.
- R13: While valid, `bit_wr_en` is (`write_mask` if the code is 5, 6, 9, 10 or 13, else all ones) ANDed with the upper byte enable `~wr_hi_n` and the lower byte enable `~wr_lo_n`, each sampled at the completing edge. `mask_active` is high for exactly those five codes. When not valid, `bit_wr_en` and `wr_data` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| row_stb_n | input | 1 | Row strobe, active low |
| col_stb_n | input | 1 | Column strobe, active low |
| xfer_oe_n | input | 1 | Transfer / output-enable pin |
| wr_hi_n | input | 1 | Upper-byte write enable, active low |
| wr_lo_n | input | 1 | Lower-byte write enable, active low |
| func_flag | input | 1 | Special-function flag |
| func_flag_rsv | input | 1 | Reserved function flag, must be low |
| pin_data | input | 16 | Data pins (mask, color or write data) |
| cyc_valid | output | 1 | Decoded cycle report is valid |
| cyc_code | output | 5 | Decoded cycle code |
| cyc_illegal | output | 1 | Valid cycle matched no legal pattern |
| mask_active | output | 1 | Current cycle applies the write mask |
| write_mask | output | 16 | Stored write mask, 1 = bit writable |
| bit_wr_en | output | 16 | Per-bit write enable for the datapath |
| wr_data | output | 16 | Write data: color or latched pins |
| color | output | 16 | Stored color register |
| persist | output | 1 | Stored mask is reused by masked cycles |
| boundary_on | output | 1 | Boundary/stop setting active |
| refresh_row | output | 9 | Refresh row counter |

## Verification
The assertions check four things on every clock:
- the report drops after the row strobe rises, and the code does not change while it stays valid;
- the refresh counter only ever steps by one;
- a persistent mask stays fixed except when a mask load completes;
- the reset-refresh cycle leaves the mask, the persist flag and the boundary flag cleared, and masked enables never exceed the stored mask.

The bench scenarios are needed for the rest:
- the full opcode decode across both strobe edges;
- mask capture on the first masked cycle;
- color substitution in block and flash writes;
- byte gating;
- wrap-around of the refresh counter after 512 refreshes.

// File: rtl/vcd_pkg.sv
package vcd_pkg;

  typedef enum logic [4:0] {
    C_NONE      = 5'd0,
    C_REF_STOP  = 5'd1,
    C_REF_RST   = 5'd2,
    C_REF_PLAIN = 5'd3,
    C_OPTION    = 5'd4,
    C_XW_MASK   = 5'd5,
    C_XW_SPLIT  = 5'd6,
    C_XR        = 5'd7,
    C_XR_SPLIT  = 5'd8,
    C_RW_MASK   = 5'd9,
    C_BLK_MASK  = 5'd10,
    C_RW        = 5'd11,
    C_BLK       = 5'd12,
    C_FLASH     = 5'd13,
    C_LD_MASK   = 5'd14,
    C_LD_COLOR  = 5'd15,
    C_ILLEGAL   = 5'd31
  } cyc_e;

  // Pin pattern captured at the row-strobe fall.
  typedef struct packed {
    logic cas;  // column strobe level
    logic oe;   // transfer / output-enable level
    logic we;   // merged write-enable level
    logic f1;   // special-function flag
    logic f2;   // reserved flag
  } rowop_t;

  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_COL  = 2'd1,
    PH_HOLD = 2'd2
  } phase_e;

  // The cycle is resolved only at the column fall.
  function automatic logic op_needs_col(rowop_t op);
    return !op.f2 && op.cas && op.oe && !(!op.we && op.f1);
  endfunction

  // Row-time patterns that apply the write mask.
  function automatic logic op_masked(rowop_t op);
    return !op.f2 && op.cas && !op.we;
  endfunction

  function automatic logic code_masked(cyc_e c);
    return (c == C_XW_MASK) || (c == C_XW_SPLIT) || (c == C_RW_MASK) ||
           (c == C_BLK_MASK) || (c == C_FLASH);
  endfunction

  function automatic logic code_color(cyc_e c);
    return (c == C_BLK_MASK) || (c == C_BLK) || (c == C_FLASH);
  endfunction

  function automatic logic code_refresh(cyc_e c);
    return (c == C_REF_STOP) || (c == C_REF_RST) || (c == C_REF_PLAIN);
  endfunction

endpackage

// File: rtl/vcd_fall_det.sv
module vcd_fall_det #(
  parameter int N = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] lvl_n,
  output logic [N-1:0] fall
);
  logic [N-1:0] prev_q;

  for (genvar i = 0; i < N; i++) begin : g_lane
    always_ff @(posedge clk) begin
      if (!rst_n) prev_q[i] <= 1'b1;
      else        prev_q[i] <= lvl_n[i];
    end
    assign fall[i] = prev_q[i] & ~lvl_n[i];
  end
endmodule

// File: rtl/vcd_decode.sv
module vcd_decode
  import vcd_pkg::*;
(
  input  rowop_t op,
  input  logic   col_f1,
  output cyc_e   code
);
  always_comb begin
    code = C_ILLEGAL;
    if (op.f2) begin
      code = C_ILLEGAL;
    end else if (!op.cas) begin
      unique case ({op.we, op.f1})
        2'b01:   code = C_REF_STOP;
        2'b10:   code = C_REF_RST;
        2'b11:   code = C_REF_PLAIN;
        default: code = op.oe ? C_ILLEGAL : C_OPTION;
      endcase
    end else if (!op.oe) begin
      unique case ({op.we, op.f1})
        2'b00:   code = C_XW_MASK;
        2'b01:   code = C_XW_SPLIT;
        2'b10:   code = C_XR;
        default: code = C_XR_SPLIT;
      endcase
    end else begin
      unique case ({op.we, op.f1})
        2'b01:   code = C_FLASH;
        2'b00:   code = col_f1 ? C_BLK_MASK : C_RW_MASK;
        2'b10:   code = col_f1 ? C_BLK : C_RW;
        default: code = col_f1 ? C_LD_COLOR : C_LD_MASK;
      endcase
    end
  end
endmodule

// File: rtl/vcd_regs.sv
module vcd_regs
  import vcd_pkg::*;
#(
  parameter int DW  = 16,
  parameter int RCW = 9
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           row_fire,
  input  cyc_e           row_code,
  input  logic           row_masked,
  input  logic           col_fire,
  input  cyc_e           col_code,
  input  logic [DW-1:0]  din,
  output logic [DW-1:0]  mask_q,
  output logic           persist_q,
  output logic [DW-1:0]  color_q,
  output logic           stop_q,
  output logic [RCW-1:0] ref_q
);
  localparam logic [RCW-1:0] REF_ONE = RCW'(1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mask_q    <= '0;
      persist_q <= 1'b0;
      color_q   <= '0;
      stop_q    <= 1'b0;
      ref_q     <= '0;
    end else begin
      if (row_fire) begin
        // First masked cycle captures the mask; later ones reuse it.
        if (row_masked && !persist_q) begin
          mask_q    <= din;
          persist_q <= 1'b1;
        end
        if (code_refresh(row_code)) ref_q <= ref_q + REF_ONE;
        if (row_code == C_REF_STOP) stop_q <= 1'b1;
        if (row_code == C_REF_RST) begin
          mask_q    <= '0;
          persist_q <= 1'b0;
          stop_q    <= 1'b0;
        end
      end
      if (col_fire) begin
        if (col_code == C_LD_MASK) begin
          mask_q    <= din;
          persist_q <= 1'b1;
        end
        if (col_code == C_LD_COLOR) color_q <= din;
      end
    end
  end
endmodule

// File: rtl/vram_cycle_ctrl.sv
module vram_cycle_ctrl
  import vcd_pkg::*;
#(
  parameter int DW  = 16,
  parameter int RCW = 9
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           row_stb_n,
  input  logic           col_stb_n,
  input  logic           xfer_oe_n,
  input  logic           wr_hi_n,
  input  logic           wr_lo_n,
  input  logic           func_flag,
  input  logic           func_flag_rsv,
  input  logic [DW-1:0]  pin_data,
  output logic           cyc_valid,
  output logic [4:0]     cyc_code,
  output logic           cyc_illegal,
  output logic           mask_active,
  output logic [DW-1:0]  write_mask,
  output logic [DW-1:0]  bit_wr_en,
  output logic [DW-1:0]  wr_data,
  output logic [DW-1:0]  color,
  output logic           persist,
  output logic           boundary_on,
  output logic [RCW-1:0] refresh_row
);
  localparam int HALF = DW / 2;

  logic [1:0] fall;
  logic       row_fall, col_fall, col_fire;
  rowop_t     live_op, op_q;
  cyc_e       row_code, col_code, code_q;
  phase_e     phase_q;
  logic       valid_q;
  logic [1:0] be_q;
  logic [DW-1:0] data_q;
  logic [DW-1:0] mask_sel;

  vcd_fall_det #(.N(2)) u_fall (
    .clk   (clk),
    .rst_n (rst_n),
    .lvl_n ({row_stb_n, col_stb_n}),
    .fall  (fall)
  );
  assign row_fall = fall[1];
  assign col_fall = fall[0];

  assign live_op = '{cas: col_stb_n, oe: xfer_oe_n, we: wr_hi_n & wr_lo_n,
                     f1: func_flag, f2: func_flag_rsv};

  vcd_decode u_dec_row (.op(live_op), .col_f1(1'b0),      .code(row_code));
  vcd_decode u_dec_col (.op(op_q),    .col_f1(func_flag), .code(col_code));

  assign col_fire = (phase_q == PH_COL) && col_fall && !row_stb_n;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase_q <= PH_IDLE;
      valid_q <= 1'b0;
      code_q  <= C_NONE;
      op_q    <= '0;
      be_q    <= 2'b00;
      data_q  <= '0;
    end else if (row_stb_n) begin
      phase_q <= PH_IDLE;
      valid_q <= 1'b0;
      code_q  <= C_NONE;
    end else if (row_fall) begin
      op_q   <= live_op;
      data_q <= pin_data;
      if (op_needs_col(live_op)) begin
        phase_q <= PH_COL;
        valid_q <= 1'b0;
        code_q  <= C_NONE;
      end else begin
        phase_q <= PH_HOLD;
        valid_q <= 1'b1;
        code_q  <= row_code;
        be_q    <= ~{wr_hi_n, wr_lo_n};
      end
    end else if (col_fire) begin
      phase_q <= PH_HOLD;
      valid_q <= 1'b1;
      code_q  <= col_code;
      data_q  <= pin_data;
      be_q    <= ~{wr_hi_n, wr_lo_n};
    end
  end

  vcd_regs #(.DW(DW), .RCW(RCW)) u_regs (
    .clk        (clk),
    .rst_n      (rst_n),
    .row_fire   (row_fall),
    .row_code   (row_code),
    .row_masked (op_masked(live_op)),
    .col_fire   (col_fire),
    .col_code   (col_code),
    .din        (pin_data),
    .mask_q     (write_mask),
    .persist_q  (persist),
    .color_q    (color),
    .stop_q     (boundary_on),
    .ref_q      (refresh_row)
  );

  assign cyc_valid   = valid_q;
  assign cyc_code    = code_q;
  assign cyc_illegal = valid_q && (code_q == C_ILLEGAL);
  assign mask_active = valid_q && code_masked(code_q);
  assign mask_sel    = mask_active ? write_mask : {DW{1'b1}};

  always_comb begin
    bit_wr_en = '0;
    wr_data   = '0;
    if (valid_q) begin
      bit_wr_en = mask_sel & {{HALF{be_q[1]}}, {HALF{be_q[0]}}};
      wr_data   = code_color(code_q) ? color : data_q;
    end
  end
endmodule

// File: rtl/vcd_checker.sv
module vcd_checker #(
  parameter int DW  = 16,
  parameter int RCW = 9
) (
  input logic           clk,
  input logic           rst_n,
  input logic           row_stb_n,
  input logic           cyc_valid,
  input logic [4:0]     cyc_code,
  input logic           mask_active,
  input logic [DW-1:0]  write_mask,
  input logic [DW-1:0]  bit_wr_en,
  input logic           persist,
  input logic           boundary_on,
  input logic [RCW-1:0] refresh_row
);
  a_r6_valid_drops: assert property (@(posedge clk) disable iff (!rst_n)
    row_stb_n |=> !cyc_valid);

  a_r6_code_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc_valid && $past(cyc_valid)) |-> $stable(cyc_code));

  a_r11_refresh_step: assert property (@(posedge clk) disable iff (!rst_n)
    (refresh_row != $past(refresh_row)) |-> (refresh_row == RCW'($past(refresh_row) + 1'b1)));

  a_r8_mask_held: assert property (@(posedge clk) disable iff (!rst_n)
    (persist && $past(persist) && !($rose(cyc_valid) && cyc_code == 5'd14))
      |-> $stable(write_mask));

  a_r10_reset_clears: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(cyc_valid) && cyc_code == 5'd2) |-> (!persist && write_mask == '0 && !boundary_on));

  a_r13_within_mask: assert property (@(posedge clk) disable iff (!rst_n)
    mask_active |-> ((bit_wr_en & ~write_mask) == '0));
endmodule

bind vram_cycle_ctrl vcd_checker #(.DW(DW), .RCW(RCW)) u_chk (.*);

// File: tb/vram_cycle_ctrl_tb.sv
module vram_cycle_ctrl_tb;
  localparam int CLK_PERIOD = 10;
  localparam int DW = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic row_stb_n = 1'b1, col_stb_n = 1'b1, xfer_oe_n = 1'b1;
  logic wr_hi_n = 1'b1, wr_lo_n = 1'b1, func_flag = 1'b0, func_flag_rsv = 1'b0;
  logic [DW-1:0] pin_data = '0;
  logic cyc_valid, cyc_illegal, mask_active, persist, boundary_on;
  logic [4:0] cyc_code;
  logic [DW-1:0] write_mask, bit_wr_en, wr_data, color;
  logic [8:0] refresh_row;

  int checks = 0, fails = 0;
  bit done = 0;

  // bench model
  logic [DW-1:0] m_mask = '0, m_color = '0;
  logic m_persist = 0, m_stop = 0;
  logic [8:0] m_ref = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  vram_cycle_ctrl u_dut (.*);

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  function automatic logic [4:0] exp_code(logic cas, oe, we, f1, f2, cf1);
    if (f2) return 5'd31;
    if (!cas) begin
      case ({we, f1})
        2'b01: return 5'd1;
        2'b10: return 5'd2;
        2'b11: return 5'd3;
        default: return oe ? 5'd31 : 5'd4;
      endcase
    end
    if (!oe) return 5'd5 + 5'({we, f1});
    case ({we, f1})
      2'b01: return 5'd13;
      2'b00: return cf1 ? 5'd10 : 5'd9;
      2'b10: return cf1 ? 5'd12 : 5'd11;
      default: return cf1 ? 5'd15 : 5'd14;
    endcase
  endfunction

  function automatic bit is_masked_code(logic [4:0] c);
    return c == 5 || c == 6 || c == 9 || c == 10 || c == 13;
  endfunction

  task automatic run_cyc(input logic cas, oe, we, f1, f2, input logic [DW-1:0] rdat,
                         input logic cf1, input logic [DW-1:0] cdat,
                         input logic [1:0] rbn, input logic [1:0] cbn);
    logic need;
    logic [4:0] code;
    logic [DW-1:0] dat, msel;
    logic [1:0] be;
    string tg;
    need = !f2 && cas && oe && !(!we && f1);
    tg = f2 ? "R5" : (!cas ? "R2" : (!oe ? "R3" : "R4"));
    @(negedge clk);
    row_stb_n = 1; col_stb_n = cas; xfer_oe_n = oe; func_flag = f1; func_flag_rsv = f2;
    {wr_hi_n, wr_lo_n} = we ? 2'b11 : rbn; pin_data = rdat;
    @(negedge clk);
    row_stb_n = 0;
    code = exp_code(cas, oe, we, f1, f2, 1'b0);
    if (!f2 && cas && !we && !m_persist) begin m_mask = rdat; m_persist = 1; end
    if (!need) begin
      if (code == 1 || code == 2 || code == 3) m_ref = m_ref + 9'd1;
      if (code == 1) m_stop = 1;
      if (code == 2) begin m_mask = '0; m_persist = 0; m_stop = 0; end
    end
    @(negedge clk);
    if (need) begin
      chk("R4 wait-col valid", 32'(cyc_valid), 0);
      func_flag = cf1; pin_data = cdat; {wr_hi_n, wr_lo_n} = cbn; col_stb_n = 0;
      @(negedge clk);
      code = exp_code(cas, oe, we, f1, f2, cf1);
      if (code == 14) begin m_mask = cdat; m_persist = 1; end
      if (code == 15) m_color = cdat;
      dat = cdat; be = ~cbn;
    end else begin
      dat = rdat; be = ~(we ? 2'b11 : rbn);
    end
    chk({tg, " code"}, 32'(cyc_code), 32'(code));
    chk({tg, " valid"}, 32'(cyc_valid), 1);
    chk("R5 illegal", 32'(cyc_illegal), 32'(code == 31));
    chk("R13 mask_active", 32'(mask_active), 32'(is_masked_code(code)));
    chk(code == 14 ? "R9 mask" : (code == 2 ? "R10 mask" : "R7 R8 mask"), 32'(write_mask), 32'(m_mask));
    chk("R7 R9 R10 persist", 32'(persist), 32'(m_persist));
    chk("R10 boundary", 32'(boundary_on), 32'(m_stop));
    chk("R11 refresh", 32'(refresh_row), 32'(m_ref));
    chk("R12 color", 32'(color), 32'(m_color));
    chk("R12 wr_data", 32'(wr_data),
        32'((code == 10 || code == 12 || code == 13) ? m_color : dat));
    msel = is_masked_code(code) ? m_mask : {DW{1'b1}};
    chk("R13 bit_wr_en", 32'(bit_wr_en), 32'(msel & {{8{be[1]}}, {8{be[0]}}}));
    // R6: later column edges do not change the code
    col_stb_n = 1;
    @(negedge clk);
    col_stb_n = 0; func_flag = ~cf1; pin_data = ~cdat;
    @(negedge clk);
    chk("R6 code held", 32'(cyc_code), 32'(code));
    chk("R6 still valid", 32'(cyc_valid), 1);
    chk("R12 color after edge", 32'(color), 32'(m_color));
    row_stb_n = 1; col_stb_n = 1;
    @(negedge clk);
    chk("R6 valid drop", 32'(cyc_valid), 0);
    chk("R13 wr zero", 32'(bit_wr_en), 0);
  endtask

  function automatic logic [1:0] rnd_rb();
    int unsigned r = $urandom_range(0, 2);
    return 2'(r);
  endfunction

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk("R1 valid", 32'(cyc_valid), 0);
    chk("R1 illegal", 32'(cyc_illegal), 0);
    chk("R1 mask_active", 32'(mask_active), 0);
    chk("R1 mask", 32'(write_mask), 0);
    chk("R1 color", 32'(color), 0);
    chk("R1 persist", 32'(persist), 0);
    chk("R1 boundary", 32'(boundary_on), 0);
    chk("R1 refresh", 32'(refresh_row), 0);

    // directed: masked write transfer captures mask (R7)
    run_cyc(1, 0, 0, 0, 0, 16'hA5C3, 0, 16'h0, 2'b10, 2'b11);
    // masked read/write reuses mask (R8)
    run_cyc(1, 1, 0, 0, 0, 16'h1111, 0, 16'h2222, 2'b01, 2'b00);
    // load color then flash and block writes use it (R12)
    run_cyc(1, 1, 1, 1, 0, 16'h0, 1, 16'hBEEF, 2'b11, 2'b00);
    run_cyc(1, 1, 0, 1, 0, 16'h3333, 0, 16'h0, 2'b00, 2'b00);
    run_cyc(1, 1, 1, 0, 0, 16'h0, 1, 16'h4444, 2'b11, 2'b01);
    // load mask under persistence (R9)
    run_cyc(1, 1, 1, 1, 0, 16'h0, 0, 16'h0FF0, 2'b11, 2'b10);
    // stop set, reset refresh (R10), illegal patterns (R2, R5)
    run_cyc(0, 1, 0, 1, 0, 16'h0, 0, 16'h0, 2'b01, 2'b00);
    run_cyc(0, 0, 1, 0, 0, 16'h0, 0, 16'h0, 2'b11, 2'b00);
    run_cyc(0, 1, 0, 0, 0, 16'h5555, 0, 16'h0, 2'b00, 2'b00);
    run_cyc(1, 1, 1, 1, 1, 16'h6666, 0, 16'h0, 2'b11, 2'b00);
    run_cyc(0, 0, 0, 0, 0, 16'h7777, 0, 16'h0, 2'b10, 2'b00);

    // random mix
    for (int i = 0; i < 400; i++) begin
      run_cyc(1'($urandom), 1'($urandom), 1'($urandom), 1'($urandom),
              ($urandom_range(0, 15) == 0), 16'($urandom), 1'($urandom), 16'($urandom),
              rnd_rb(), 2'($urandom));
    end

    // R11 wrap: 512 plain refreshes return the counter to its start value
    begin
      logic [8:0] start;
      start = refresh_row;
      for (int i = 0; i < 512; i++) begin
        @(negedge clk);
        row_stb_n = 1; col_stb_n = 0; xfer_oe_n = 1; func_flag = 1; func_flag_rsv = 0;
        wr_hi_n = 1; wr_lo_n = 1;
        @(negedge clk);
        row_stb_n = 0;
      end
      @(negedge clk);
      row_stb_n = 1;
      @(negedge clk);
      chk("R11 wrap", 32'(refresh_row), 32'(start));
    end
    done = 1;
  end

  initial begin
    for (int c = 0; c < 150000 && !done; c++) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog act=running exp=done");
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule